// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a binary counter, four bits wide by default, that is stepped by two separate count strobes instead of one clock plus a direction pin. A rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. Each strobe counts only while the opposite strobe rests high. An active-high clear forces the value to zero. An active-low preset loads a parallel word. Both of these act at once on the output, with clear winning.

Two active-low terminal flags, carry and borrow, let stages chain without glue. Carry drops while the count sits at its maximum and the up strobe is low. Borrow drops while the count sits at zero and the down strobe is low. Wiring carry to the next stage's up strobe and borrow to its down strobe steps the next stage exactly once per wrap. The two strobes are sampled by a free-running system clock through synchronizers, and rising edges are found on the synchronized levels. All state lives in that clock domain.

Top module: `updown_dual_counter`

## Requirements
- R1: While the system reset `rst_n` is low, `count` reads 0 and `carry_n` and `borrow_n` read 1.
- R2: While `clr` is 1, `count` reads 0 at once, whatever `load_n`, `load_val` or the strobes do.
- R3: While `clr` is 0 and `load_n` is 0, `count` equals `load_val` at once and strobe edges do not change it. After `load_n` returns to 1, the loaded value is kept.
- R4: A rising edge of `cnt_up` while `cnt_dn` is high adds one to the count, and 15 wraps to 0.
- R5: A rising edge of `cnt_dn` while `cnt_up` is high subtracts one from the count, and 0 wraps to 15.
- R6: A rising edge on one strobe while the other strobe is low leaves the count unchanged.
- R7: When both strobes rise in the same system clock cycle, the count is unchanged.
- R8: `carry_n` is 0 only while the count is all ones and `cnt_up` is low, within three system clock cycles, and it returns to 1 once `cnt_up` rises.
- R9: `borrow_n` is 0 only while the count is 0 and `cnt_dn` is low, within three system clock cycles, and it returns to 1 once `cnt_dn` rises.
- R10: Two stages chained through carry and borrow count as one 8-bit counter, both upward and downward across the nibble boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| clr | input | 1 | Active-high master clear, overrides everything |
| load_n | input | 1 | Active-low preset enable |
| load_val | input | WIDTH | Parallel preset word |
| cnt_up | input | 1 | Up-count strobe, counts on its rising edge |
| cnt_dn | input | 1 | Down-count strobe, counts on its rising edge |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low terminal flag for counting up |
| borrow_n | output | 1 | Active-low terminal flag for counting down |

## Verification
The bench drives up-strobe trains and down-strobe trains with the idle strobe held high. These show the direction decode and the wrap in each direction. It also raises one strobe while the other is low, and raises both in the same cycle. These patterns separate an edge decode gated by the opposite level from one that counts every edge. Clear is applied on top of preset while strobes keep running, which shows the override order. Holding a strobe low at a terminal value shows the flags. A two-stage chain is run up past 16 and back down below zero, which tells a flag that fires once per wrap from one that fires at the wrong time or more than once.

// File: rtl/udc_pkg.sv
`timescale 1ns/1ps
package udc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  // Opposing events in one cycle cancel.
  function automatic step_e decode_step(input logic up_ev, input logic dn_ev);
    case ({up_ev, dn_ev})
      2'b10:   return STEP_INC;
      2'b01:   return STEP_DEC;
      default: return STEP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/udc_sync_edge.sv
`timescale 1ns/1ps
module udc_sync_edge #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {DEPTH{IDLE}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R4: an edge is reported for a single cycle only
  a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/udc_count_core.sv
`timescale 1ns/1ps
module udc_count_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  input  logic             up_ev,
  input  logic             dn_ev,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;
  step_e            step;

  always_comb begin
    step   = decode_step(up_ev, dn_ev);
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!load_n) begin
      cnt_d = load_val;
    end else begin
      case (step)
        STEP_INC: cnt_d = cnt_q + 1'b1;
        STEP_DEC: cnt_d = cnt_q - 1'b1;
        default:  cnt_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Clear and preset reach the output without waiting for a clock.
  always_comb begin
    if (clr) begin
      count_o = '0;
    end else if (!load_n) begin
      count_o = load_val;
    end else begin
      count_o = cnt_q;
    end
  end

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  a_r3_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> cnt_q == $past(load_val));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_ev && !dn_ev) |=> cnt_q == WIDTH'($past(cnt_q) + 1'b1));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && dn_ev && !up_ev) |=> cnt_q == WIDTH'($past(cnt_q) - 1'b1));

  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_ev && dn_ev) |=> $stable(cnt_q));

endmodule

// File: rtl/udc_term_flags.sv
`timescale 1ns/1ps
module udc_term_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_MIN = '0;

  logic carry_d;
  logic borrow_d;

  always_comb begin
    carry_d  = ~((count_i == CNT_MAX) & ~up_lvl);
    borrow_d = ~((count_i == CNT_MIN) & ~dn_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      carry_n  <= carry_d;
      borrow_n <= borrow_d;
    end
  end

  a_r8_carry_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> $past(count_i) == CNT_MAX);

  a_r9_borrow_at_min: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> $past(count_i) == CNT_MIN);

  a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    carry_n || borrow_n);

endmodule

// File: rtl/updown_dual_counter.sv
`timescale 1ns/1ps
module updown_dual_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam int N_STROBES = 2;
  localparam int IDX_UP    = 0;
  localparam int IDX_DN    = 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_pipe_q[1];

  logic [N_STROBES-1:0] strobe_raw;
  logic [N_STROBES-1:0] strobe_lvl;
  logic [N_STROBES-1:0] strobe_rise;

  assign strobe_raw[IDX_UP] = cnt_up;
  assign strobe_raw[IDX_DN] = cnt_dn;

  for (genvar g = 0; g < N_STROBES; g++) begin : g_strobe
    udc_sync_edge #(
      .STAGES (SYNC_STAGES),
      .IDLE   (1'b1)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_s_n),
      .din   (strobe_raw[g]),
      .lvl   (strobe_lvl[g]),
      .rise  (strobe_rise[g])
    );
  end

  logic up_ev;
  logic dn_ev;

  assign up_ev = strobe_rise[IDX_UP] & strobe_lvl[IDX_DN];
  assign dn_ev = strobe_rise[IDX_DN] & strobe_lvl[IDX_UP];

  udc_count_core #(
    .WIDTH (WIDTH)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr      (clr),
    .load_n   (load_n),
    .load_val (load_val),
    .up_ev    (up_ev),
    .dn_ev    (dn_ev),
    .count_o  (count)
  );

  udc_term_flags #(
    .WIDTH (WIDTH)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .count_i  (count),
    .up_lvl   (strobe_lvl[IDX_UP]),
    .dn_lvl   (strobe_lvl[IDX_DN]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  // R6: a count event needs the opposite strobe to be high already
  a_r6_gated_edge: assert property (@(posedge clk) disable iff (!rst_s_n)
    (strobe_rise[IDX_UP] && !strobe_lvl[IDX_DN] && !clr && load_n) |=> $stable(count));

endmodule

// File: tb/test_updown_dual_counter.sv
`timescale 1ns/1ps
module test_updown_dual_counter;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic load_n = 1'b1;
  logic [W-1:0] load_val = '0;
  logic up = 1'b1;
  logic dn = 1'b1;
  logic cu = 1'b1;
  logic cd = 1'b1;

  logic [W-1:0] count;
  logic carry_n, borrow_n;
  logic [W-1:0] lo_q, hi_q;
  logic lo_c, lo_b, hi_c, hi_b;

  always #2 clk = ~clk;

  updown_dual_counter #(.WIDTH(W)) i_updown_dual_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .load_val(load_val),
    .cnt_up(up), .cnt_dn(dn), .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

  updown_dual_counter #(.WIDTH(W)) i_lo (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .load_n(1'b1), .load_val('0),
    .cnt_up(cu), .cnt_dn(cd), .count(lo_q), .carry_n(lo_c), .borrow_n(lo_b));

  updown_dual_counter #(.WIDTH(W)) i_hi (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .load_n(1'b1), .load_val('0),
    .cnt_up(lo_c), .cnt_dn(lo_b), .count(hi_q), .carry_n(hi_c), .borrow_n(hi_b));

  typedef struct {
    bit         casc;
    bit         flags;
    logic [7:0] val;
    logic       cy;
    logic       bw;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_it(input bit casc, input bit flags, input logic [7:0] v,
                           input logic cy, input logic bw, input string tag);
    exp_t e;
    e.casc = casc; e.flags = flags; e.val = v; e.cy = cy; e.bw = bw; e.tag = tag;
    sb.push_back(e);
    cyc(2);
  endtask

  task automatic set_strobe(input int sel, input logic v);
    case (sel)
      0: up = v;
      1: dn = v;
      2: cu = v;
      default: cd = v;
    endcase
  endtask

  task automatic pulse(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      set_strobe(sel, 1'b0);
      cyc(6);
      set_strobe(sel, 1'b1);
      cyc(6);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    exp_t e;
    logic [7:0] act;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        act = e.casc ? {hi_q, lo_q} : {4'b0000, count};
        checks++;
        if (act !== e.val || (e.flags && (carry_n !== e.cy || borrow_n !== e.bw))) begin
          errors++;
          $display("FAIL %s: count=%0d carry_n=%b borrow_n=%b, expected count=%0d carry_n=%b borrow_n=%b",
                   e.tag, act, carry_n, borrow_n, e.val, e.cy, e.bw);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_it(0, 1, 8'd0, 1'b1, 1'b1, "R1 held in reset");
    rst_n = 1'b1;
    cyc(4);
    expect_it(0, 1, 8'd0, 1'b1, 1'b1, "R1 after reset release");

    pulse(0, 3); cyc(2);
    expect_it(0, 1, 8'd3, 1'b1, 1'b1, "R4 three up steps");

    load_val = 4'd13; load_n = 1'b0; cyc(1);
    expect_it(0, 0, 8'd13, 1'b1, 1'b1, "R3 preset applied");
    pulse(0, 2);
    expect_it(0, 0, 8'd13, 1'b1, 1'b1, "R3 no counting during preset");
    load_n = 1'b1; cyc(2);
    expect_it(0, 1, 8'd13, 1'b1, 1'b1, "R3 preset value kept");

    pulse(0, 2); cyc(2);
    expect_it(0, 1, 8'd15, 1'b1, 1'b1, "R4 up to maximum");
    up = 1'b0; cyc(6);
    expect_it(0, 1, 8'd15, 1'b0, 1'b1, "R8 carry low at maximum");
    up = 1'b1; cyc(8);
    expect_it(0, 1, 8'd0, 1'b1, 1'b1, "R4 R8 wrap to zero, carry released");

    dn = 1'b0; cyc(6);
    expect_it(0, 1, 8'd0, 1'b1, 1'b0, "R9 borrow low at zero");
    dn = 1'b1; cyc(8);
    expect_it(0, 1, 8'd15, 1'b1, 1'b1, "R5 R9 wrap to 15, borrow released");
    pulse(1, 2); cyc(2);
    expect_it(0, 1, 8'd13, 1'b1, 1'b1, "R5 two down steps");

    dn = 1'b0; cyc(6);
    pulse(0, 1); cyc(2);
    expect_it(0, 1, 8'd13, 1'b1, 1'b1, "R6 up edge ignored while down low");
    dn = 1'b1; cyc(8);
    expect_it(0, 1, 8'd12, 1'b1, 1'b1, "R5 R6 down edge with up high");

    up = 1'b0; dn = 1'b0; cyc(6);
    up = 1'b1; dn = 1'b1; cyc(8);
    expect_it(0, 1, 8'd12, 1'b1, 1'b1, "R7 simultaneous rise");

    load_val = 4'd7; load_n = 1'b0; clr = 1'b1; cyc(1);
    expect_it(0, 1, 8'd0, 1'b1, 1'b1, "R2 clear beats preset");
    pulse(0, 1);
    expect_it(0, 0, 8'd0, 1'b1, 1'b1, "R2 counting blocked by clear");
    clr = 1'b0; cyc(1);
    expect_it(0, 0, 8'd7, 1'b1, 1'b1, "R3 preset after clear release");
    load_n = 1'b1; cyc(2);
    expect_it(0, 1, 8'd7, 1'b1, 1'b1, "R3 value kept after release");

    rst_n = 1'b0; cyc(1);
    expect_it(0, 1, 8'd0, 1'b1, 1'b1, "R1 reset in mid-run");
    rst_n = 1'b1; cyc(4);

    pulse(2, 20); cyc(6);
    expect_it(1, 0, 8'd20, 1'b1, 1'b1, "R10 chained up count");
    pulse(3, 25); cyc(6);
    expect_it(1, 0, 8'd251, 1'b1, 1'b1, "R10 chained down count");

    cyc(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule